// File: doc/BRIEF.md
# Cache Line Coherency State Controller

This block keeps the coherency state of every line in a small direct-mapped write-back cache and moves those states in response to two sources of events. The processor side presents one operation per cycle against an address: fill after a read miss, write, or evict. Each operation comes back with the looked-up line state, hit and modified flags, a pulse when a write must also go to memory, and a copy-back flag with the victim address when a modified line is about to be displaced. The data array, replacement choice and bus timing live outside; this block only holds tags and the two status bits per line.

The snoop side takes requests from another bus master, each with an address and an invalidate flag. A snoop hit on a clean line changes the state in place. A snoop hit on a dirty line makes the block hold the other master off the bus and request a write-back of that line. When the write-back is acknowledged the line is downgraded and the hold is released, so that the master can retry and read fresh data from memory.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Line states are coded 00 invalid, 01 exclusive, 10 modified, 11 shared on `cpu_state_o`, which shows the state of the line addressed by `cpu_addr_i` on a tag match and 00 otherwise. After reset every line is invalid.
- R2: An invalid line never produces a hit, neither on the processor lookup nor on a snoop.
- R3: A fill (`cpu_op_i`=01) allocates the addressed line with its tag, entering exclusive when `cpu_wt_i`=0 and shared when `cpu_wt_i`=1. A fill or evict whose indexed line is modified raises `copyback_o` in the same cycle, with that line's address on `victim_addr_o`.
- R4: A write (`cpu_op_i`=10) that hits a shared line raises `wt_write_o` in the same cycle and leaves the line shared.
- R5: A write that hits an exclusive line moves it to modified. A write that hits a modified line keeps it modified. Neither raises `wt_write_o`.
- R6: A write that misses allocates nothing and changes no line state.
- R7: A snoop hit on an exclusive or shared line sets `snp_hit_o` in the next cycle and moves the line to shared, or to invalid when `snp_inv_i` is set.
- R8: A snoop hit on a modified line raises `snp_hit_o`, `snp_hitm_o`, `backoff_o` and `wb_req_o` in the next cycle, with the line address on `wb_addr_o`. Back-off and request hold until `wb_ack_i`. The line then becomes shared, or invalid if the snoop asked for invalidation, and `backoff_o` falls in the cycle after the acknowledge.
- R9: `cpu_stall_o` is high while a write-back is pending or `snp_valid_i` is high. Processor operations presented while it is high change no state and raise neither `wt_write_o` nor `copyback_o`.
- R10: While a write-back is pending, new snoop requests are ignored and produce no hit indication. `wb_ack_i` outside a pending write-back has no effect.
- R11: An evict (`cpu_op_i`=11) moves the indexed line to invalid whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op_i | input | 2 | Processor operation: 00 none, 01 fill, 10 write, 11 evict |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wt_i | input | 1 | Fill policy: 1 write-through (shared), 0 write-back (exclusive) |
| cpu_stall_o | output | 1 | Processor operation will not be accepted this cycle |
| cpu_state_o | output | 2 | State of the addressed line on tag match, else invalid |
| cpu_hit_o | output | 1 | Processor address hits a valid line |
| cpu_mod_o | output | 1 | Processor hit is on a modified line |
| wt_write_o | output | 1 | Write must also be sent to memory |
| copyback_o | output | 1 | Displaced line is modified and must be copied back |
| victim_addr_o | output | 16 | Address of the line at the processor index |
| snp_valid_i | input | 1 | Snoop request |
| snp_addr_i | input | 16 | Snoop address |
| snp_inv_i | input | 1 | Snoop asks for invalidation |
| snp_hit_o | output | 1 | Previous-cycle snoop hit a valid line |
| snp_hitm_o | output | 1 | Previous-cycle snoop hit a modified line |
| backoff_o | output | 1 | Other master must leave the bus |
| wb_req_o | output | 1 | Write-back of the snooped line requested |
| wb_addr_o | output | 16 | Address of the line to write back |
| wb_ack_i | input | 1 | Write-back finished |

## Verification
On every cycle the embedded assertions check the ordering of the dirty-snoop handshake: a modified hit is always followed by back-off, back-off never drops without an acknowledge, and the write-back address stays still while it is held. They also check that the modified state is only reached from exclusive, that a through-write is only flagged on a clean hit, and that nothing is written from the processor side while stalled. Whether each operation lands the right encoding in the right line, whether misses leave states untouched, and whether ignored snoops really change nothing can only be shown by the bench's scenarios, which compare every output against a reference model of the line table.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_EXC = 2'b01,
        LS_MOD = 2'b10,
        LS_SHR = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_FILL  = 2'b01,
        OP_WRITE = 2'b10,
        OP_EVICT = 2'b11
    } cpu_op_e;

    // State after a processor operation that is accepted.
    function automatic line_st_e cpu_next(cpu_op_e op, line_st_e cur, logic hit, logic wt);
        line_st_e nxt;
        nxt = cur;
        case (op)
            OP_FILL:  nxt = wt ? LS_SHR : LS_EXC;
            OP_WRITE: if (hit && cur == LS_EXC) nxt = LS_MOD;
            OP_EVICT: nxt = LS_INV;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

    // State after a snoop hit has been resolved.
    function automatic line_st_e snoop_next(line_st_e cur, logic inv);
        if (inv || cur == LS_INV) return LS_INV;
        return LS_SHR;
    endfunction

    function automatic logic op_writes(cpu_op_e op, logic hit);
        case (op)
            OP_FILL, OP_EVICT: return 1'b1;
            OP_WRITE:          return hit;
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_e         a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_e         b_st,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_tag_en,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_e         w_st
);

    logic [TAG_W-1:0] tag_q [LINES];
    line_st_e         st_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = we && (w_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= LS_INV;
                tag_q[g] <= '0;
            end else if (sel) begin
                st_q[g] <= w_st;
                if (w_tag_en) tag_q[g] <= w_tag;
            end
        end
    end

    assign a_tag = tag_q[a_idx];
    assign a_st  = st_q[a_idx];
    assign b_tag = tag_q[b_idx];
    assign b_st  = st_q[b_idx];

endmodule

// File: rtl/mesi_cpu_ctl.sv
module mesi_cpu_ctl
    import mesi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_op_e  op,
    input  logic     stall,
    input  logic     hit,
    input  line_st_e cur_st,
    input  logic     wt,
    output logic     upd_en,
    output logic     upd_tag_en,
    output line_st_e upd_st,
    output logic     wt_write,
    output logic     copyback
);

    logic go;
    assign go         = !stall;
    assign upd_en     = go && op_writes(op, hit);
    assign upd_tag_en = (op == OP_FILL);
    assign upd_st     = cpu_next(op, cur_st, hit, wt);
    assign wt_write   = go && (op == OP_WRITE) && hit && (cur_st == LS_SHR);
    assign copyback   = go && (op == OP_FILL || op == OP_EVICT) && (cur_st == LS_MOD);

    // R5
    mod_from_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op == OP_WRITE && upd_st == LS_MOD) |-> (cur_st inside {LS_EXC, LS_MOD}));

    // R4
    wt_clean_chk: assert property (@(posedge clk) disable iff (rst)
        wt_write |-> (hit && cur_st != LS_MOD && cur_st != LS_INV));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!upd_en && !wt_write && !copyback));

endmodule

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int ADDR_W = 16,
    localparam int OFF_W = ADDR_W - IDX_W - TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic              snp_inv,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              look_hit,
    input  line_st_e          look_st,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic              wb_ack,
    output logic              busy,
    output logic              hit_q,
    output logic              hitm_q,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_e          upd_st
);

    typedef enum logic {SN_IDLE, SN_HOLD} sn_fsm_e;

    sn_fsm_e          fsm_q;
    logic [IDX_W-1:0] idx_q;
    logic             inv_q;
    logic             take;
    logic             dirty;

    assign take  = (fsm_q == SN_IDLE) && snp_valid && look_hit;
    assign dirty = take && (look_st == LS_MOD);
    assign busy  = (fsm_q == SN_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= SN_IDLE;
            idx_q   <= '0;
            inv_q   <= 1'b0;
            hit_q   <= 1'b0;
            hitm_q  <= 1'b0;
            wb_addr <= '0;
        end else begin
            hit_q  <= take;
            hitm_q <= dirty;
            case (fsm_q)
                SN_IDLE: if (dirty) begin
                    fsm_q   <= SN_HOLD;
                    idx_q   <= snp_idx;
                    inv_q   <= snp_inv;
                    wb_addr <= {look_tag, snp_idx, {OFF_W{1'b0}}};
                end
                SN_HOLD: if (wb_ack) fsm_q <= SN_IDLE;
                default: fsm_q <= SN_IDLE;
            endcase
        end
    end

    always_comb begin
        upd_en  = 1'b0;
        upd_idx = snp_idx;
        upd_st  = snoop_next(look_st, snp_inv);
        if (busy) begin
            upd_en  = wb_ack;
            upd_idx = idx_q;
            upd_st  = inv_q ? LS_INV : LS_SHR;
        end else if (take && !dirty) begin
            upd_en = 1'b1;
        end
    end

    // R8
    hitm_holds_chk: assert property (@(posedge clk) disable iff (rst)
        hitm_q |-> busy);

    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wb_ack) |=> busy);

    // R8
    release_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wb_ack) |=> !busy);

    // R8
    wb_addr_still_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wb_addr));

    // R10
    no_hit_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !hit_q);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_op_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_wt_i,
    output logic              cpu_stall_o,
    output logic [1:0]        cpu_state_o,
    output logic              cpu_hit_o,
    output logic              cpu_mod_o,
    output logic              wt_write_o,
    output logic              copyback_o,
    output logic [ADDR_W-1:0] victim_addr_o,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic              snp_inv_i,
    output logic              snp_hit_o,
    output logic              snp_hitm_o,
    output logic              backoff_o,
    output logic              wb_req_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    input  logic              wb_ack_i
);

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag, c_tag_q, s_tag_q;
    line_st_e         c_st, s_st;
    logic             c_hit, s_hit;
    logic             unused_off;

    assign c_idx = cpu_addr_i[OFF_W +: IDX_W];
    assign c_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
    assign s_idx = snp_addr_i[OFF_W +: IDX_W];
    assign s_tag = snp_addr_i[ADDR_W-1 -: TAG_W];
    assign unused_off = ^{cpu_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0]};

    logic             we, w_tag_en;
    logic [IDX_W-1:0] w_idx;
    line_st_e         w_st;

    mesi_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(c_idx), .a_tag(c_tag_q), .a_st(c_st),
        .b_idx(s_idx), .b_tag(s_tag_q), .b_st(s_st),
        .we(we), .w_idx(w_idx), .w_tag_en(w_tag_en), .w_tag(c_tag), .w_st(w_st)
    );

    assign c_hit = (c_st != LS_INV) && (c_tag_q == c_tag);
    assign s_hit = (s_st != LS_INV) && (s_tag_q == s_tag);

    logic     sn_busy, sn_upd_en;
    logic [IDX_W-1:0] sn_upd_idx;
    line_st_e sn_upd_st;

    mesi_snoop_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid_i), .snp_inv(snp_inv_i), .snp_idx(s_idx),
        .look_hit(s_hit), .look_st(s_st), .look_tag(s_tag_q),
        .wb_ack(wb_ack_i),
        .busy(sn_busy), .hit_q(snp_hit_o), .hitm_q(snp_hitm_o),
        .wb_addr(wb_addr_o),
        .upd_en(sn_upd_en), .upd_idx(sn_upd_idx), .upd_st(sn_upd_st)
    );

    logic     stall, cp_upd_en, cp_tag_en;
    line_st_e cp_upd_st;

    assign stall = sn_busy || snp_valid_i;

    mesi_cpu_ctl u_cpu (
        .clk(clk), .rst(rst),
        .op(cpu_op_e'(cpu_op_i)), .stall(stall), .hit(c_hit), .cur_st(c_st),
        .wt(cpu_wt_i),
        .upd_en(cp_upd_en), .upd_tag_en(cp_tag_en), .upd_st(cp_upd_st),
        .wt_write(wt_write_o), .copyback(copyback_o)
    );

    // Snoop side owns the write port whenever the processor is stalled.
    always_comb begin
        if (sn_upd_en) begin
            we = 1'b1; w_idx = sn_upd_idx; w_tag_en = 1'b0; w_st = sn_upd_st;
        end else begin
            we = cp_upd_en; w_idx = c_idx; w_tag_en = cp_tag_en; w_st = cp_upd_st;
        end
    end

    assign cpu_stall_o   = stall;
    assign cpu_hit_o     = c_hit;
    assign cpu_mod_o     = c_hit && (c_st == LS_MOD);
    assign cpu_state_o   = c_hit ? c_st : LS_INV;
    assign victim_addr_o = {c_tag_q, c_idx, {OFF_W{1'b0}}};
    assign backoff_o     = sn_busy;
    assign wb_req_o      = sn_busy;

    // R8
    backoff_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(backoff_o) |-> $past(snp_valid_i && s_hit && s_st == LS_MOD));

    // R9
    port_clash_chk: assert property (@(posedge clk) disable iff (rst)
        sn_upd_en |-> !cp_upd_en);

    // R2
    inv_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_hit_o |-> (cpu_state_o != 2'b00));

endmodule

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;

    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_op_i = 2'b00;
    logic [15:0] cpu_addr_i = '0;
    logic        cpu_wt_i = 1'b0;
    logic        cpu_stall_o, cpu_hit_o, cpu_mod_o, wt_write_o, copyback_o;
    logic [1:0]  cpu_state_o;
    logic [15:0] victim_addr_o, wb_addr_o;
    logic        snp_valid_i = 1'b0, snp_inv_i = 1'b0, wb_ack_i = 1'b0;
    logic [15:0] snp_addr_i = '0;
    logic        snp_hit_o, snp_hitm_o, backoff_o, wb_req_o;

    mesi_line_ctrl dut (.*);

    always #2.5 clk = ~clk;

    int compared = 0, mismatched = 0;

    // reference model
    int m_st [NL];
    int m_tag[NL];
    bit m_busy, m_hit, m_hitm, m_inv;
    int m_widx;
    logic [15:0] m_wbaddr;

    function automatic int f_idx(logic [15:0] a); return int'(a[6:4]); endfunction
    function automatic int f_tag(logic [15:0] a); return int'(a[15:7]); endfunction
    function automatic bit f_hit(logic [15:0] a);
        return m_st[f_idx(a)] != 0 && m_tag[f_idx(a)] == f_tag(a);
    endfunction
    function automatic logic [15:0] f_line(int tag, int idx);
        return {tag[8:0], idx[2:0], 4'b0000};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
        m_busy = 0; m_hit = 0; m_hitm = 0; m_inv = 0; m_widx = 0; m_wbaddr = '0;
    endtask

    // One cycle: drive at negedge, check, then advance the model past posedge.
    task automatic step(int op, logic [15:0] a, bit wt, bit sv, logic [15:0] sa, bit si, bit ack);
        bit stall, h, sh;
        int ci, si_idx, st;
        @(negedge clk);
        cpu_op_i = op[1:0]; cpu_addr_i = a; cpu_wt_i = wt;
        snp_valid_i = sv; snp_addr_i = sa; snp_inv_i = si; wb_ack_i = ack;
        #1;
        ci = f_idx(a); h = f_hit(a); st = m_st[ci];
        stall = m_busy || sv;
        chk("R9", "stall", cpu_stall_o, stall);
        chk("R2", "cpu_hit", cpu_hit_o, h);
        chk("R1", "cpu_state", cpu_state_o, h ? st : 0);
        chk("R5", "cpu_mod", cpu_mod_o, h && st == 2);
        chk("R4", "wt_write", wt_write_o, !stall && op == 2 && h && st == 3);
        chk("R3", "copyback", copyback_o, !stall && (op == 1 || op == 3) && st == 2);
        chk("R3", "victim_addr", victim_addr_o, f_line(m_tag[ci], ci));
        chk("R7", "snp_hit", snp_hit_o, m_hit);
        chk("R8", "snp_hitm", snp_hitm_o, m_hitm);
        chk("R8", "backoff", backoff_o, m_busy);
        chk("R8", "wb_req", wb_req_o, m_busy);
        if (m_busy) chk("R8", "wb_addr", wb_addr_o, m_wbaddr);
        @(posedge clk);
        if (!stall) begin
            case (op)
                1: begin m_tag[ci] = f_tag(a); m_st[ci] = wt ? 3 : 1; end
                2: if (h && st == 1) m_st[ci] = 2;
                3: m_st[ci] = 0;
                default: ;
            endcase
        end
        if (m_busy) begin
            m_hit = 0; m_hitm = 0;
            if (ack) begin m_st[m_widx] = m_inv ? 0 : 3; m_busy = 0; end
        end else if (sv) begin
            si_idx = f_idx(sa); sh = f_hit(sa);
            m_hit = sh; m_hitm = sh && m_st[si_idx] == 2;
            if (m_hitm) begin
                m_busy = 1; m_widx = si_idx; m_inv = si;
                m_wbaddr = f_line(m_tag[si_idx], si_idx);
            end else if (sh) m_st[si_idx] = si ? 0 : 3;
        end else begin
            m_hit = 0; m_hitm = 0;
        end
    endtask

    task automatic idle(); step(0, '0, 0, 0, '0, 0, 0); endtask

    initial begin : watchdog
        #900000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        logic [15:0] a0, a1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset: every line invalid
        for (int i = 0; i < NL; i++) step(0, f_line(0, i), 0, 0, '0, 0, 0);

        a0 = f_line(5, 2); a1 = f_line(6, 2);
        step(2, a0, 0, 0, '0, 0, 0);              // R6 write miss, no allocate
        step(0, a0, 0, 0, '0, 0, 0);
        step(1, a0, 0, 0, '0, 0, 0);              // R3 fill exclusive
        step(2, a0, 0, 0, '0, 0, 0);              // R5 exclusive -> modified
        step(2, a0, 0, 0, '0, 0, 0);              // R5 stays modified
        step(1, a0, 1, 1, a0, 0, 0);              // R8 dirty snoop, R9 fill ignored
        step(2, a0, 0, 1, a0, 1, 0);              // R10 snoop during hold ignored
        step(0, a0, 0, 0, '0, 0, 0);
        step(0, a0, 0, 0, '0, 0, 1);              // R8 ack -> shared
        step(2, a0, 0, 0, '0, 0, 1);              // R4 write-through, R10 stray ack
        step(1, a1, 0, 0, '0, 0, 0);              // R3 replace clean line
        step(2, a1, 0, 0, '0, 0, 0);
        step(3, a1, 0, 0, '0, 0, 0);              // R11 evict dirty, copyback
        step(1, a1, 1, 0, '0, 0, 0);              // R3 fill shared
        step(0, '0, 0, 1, a1, 1, 0);              // R7 snoop invalidate clean
        step(1, a0, 0, 0, '0, 0, 0);
        step(0, '0, 0, 1, a0, 0, 0);              // R7 exclusive -> shared
        step(0, a0, 0, 0, '0, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            int op, ack;
            bit sv;
            logic [15:0] ra, rs;
            op = int'($urandom % 4);
            ra = f_line(int'($urandom % 2), int'($urandom % NL)) | 16'($urandom % 16);
            rs = f_line(int'($urandom % 2), int'($urandom % NL));
            sv = ($urandom % 4) == 0;
            ack = (m_busy && ($urandom % 3) == 0) || ($urandom % 16) == 0;
            step(op, ra, $urandom % 2, sv, rs, $urandom % 2, ack[0]);
        end
        repeat (6) step(0, '0, 0, 0, '0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial void'($urandom(32'd1357));

endmodule